// File: doc/BRIEF.md
# Slice-driven transition table tile

This block is one lane of a multi-pattern scanner. Each byte of a packet is cut into narrow bit slices, and a separate tile walks a small state machine over one slice. The tile keeps a loadable table indexed by its current state. Every row of that table holds a set of successor pointers and a candidate vector. The candidate vector has one bit per rule and marks which rules could still be matching at that state. A byte counts as matching a rule only where the candidate vectors of all sibling tiles agree, and that combining is done outside this block.

For each accepted slice, the tile looks up the row of its current state and registers that row's candidate vector onto its output. The slice value selects one of the row's successor pointers, and that pointer becomes the new state. A start-of-packet strobe sends the walk back to state 0. The table is loaded through a write port while no slice is being presented, so a different rule set can be installed between packets. The datapath is the same whatever the table holds.

Top module: `slice_tile`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `hit_valid` is 0 and `hit_vec` is all zero.
- R2: Reset clears every table row. With an unloaded table, every accepted slice yields an all-zero `hit_vec`, and the walk stays in state 0.
- R3: When `in_valid` is 1 at a rising edge, in the following cycle `hit_valid` is 1 and `hit_vec` equals the candidate vector of the row being read.
- R4: After an accepted slice, the new state is the successor pointer in bits [8k+7:8k] of that row's pointer field, where k is the 2-bit slice value. Every 8-bit state value, including 255, can be reached.
- R5: `pkt_start` returns the walk to state 0. If it arrives together with a valid slice, that slice is looked up in row 0. If it arrives alone, the next slice is looked up in row 0.
- R6: In a cycle without `in_valid`, the next cycle shows `hit_valid` 0 and `hit_vec` all zero, and the state is kept, so the walk resumes where it stopped.
- R7: A table write presented while `in_valid` is 1 is discarded, and the row keeps its old contents.
- R8: A table write presented while `in_valid` is 0 replaces the pointer field and the candidate vector of row `tw_addr`. The new contents apply to the next lookup of that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_start | input | 1 | Start of packet: return the walk to state 0 |
| in_valid | input | 1 | Slice present this cycle |
| in_slice | input | 2 | Bit slice of the current byte; selects the successor pointer |
| tw_en | input | 1 | Table write request |
| tw_addr | input | 8 | Row to write |
| tw_ptrs | input | 32 | Four successor pointers; pointer k sits in bits [8k+7:8k] |
| tw_hits | input | 16 | Candidate vector for the row |
| hit_valid | output | 1 | `hit_vec` carries the result of a slice accepted in the previous cycle |
| hit_vec | output | 16 | Registered candidate vector; zero when no slice was accepted |

## Verification
A wrong internal state shows up at the ports only indirectly. It appears as a candidate vector from a different row, one cycle after the slice that reads from the wrong state. To expose it, every programmed row carries a distinct vector, so a wrong step is seen at the very next accepted slice. A lost or held state after an idle cycle or a start-of-packet strobe surfaces in the same way, on the first slice that follows. A write that was wrongly taken or wrongly dropped only shows once the walk revisits that row, so the stimulus returns to row 0 right after each such write.

// File: rtl/slice_tile_pkg.sv
package slice_tile_pkg;
  // Source of the next state value for the walk register
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_ROOT = 2'd1,
    SRC_STEP = 2'd2
  } state_src_e;

  // Choose how the state register updates this cycle
  function automatic state_src_e pick_src(input logic valid, input logic start);
    if (valid)      return SRC_STEP;
    else if (start) return SRC_ROOT;
    else            return SRC_HOLD;
  endfunction
endpackage

// File: rtl/slice_tile_table.sv
module slice_tile_table #(
  parameter int ADDR_W  = 8,
  parameter int ENTRY_W = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [ADDR_W-1:0]  waddr,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic [ADDR_W-1:0]  raddr,
  output logic [ENTRY_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ENTRY_W-1:0] rows [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) rows[i] <= '0;
    end else if (we) begin
      rows[waddr] <= wdata;
    end
  end

  assign rdata = rows[raddr];
endmodule

// File: rtl/slice_tile_ptr_mux.sv
module slice_tile_ptr_mux #(
  parameter int STATE_W = 8,
  parameter int SLICE_W = 2
) (
  input  logic [(STATE_W << SLICE_W)-1:0] ptr_bus,
  input  logic [SLICE_W-1:0]              sel,
  output logic [STATE_W-1:0]              nxt
);
  localparam int FANOUT = 1 << SLICE_W;

  logic [STATE_W-1:0] lane [FANOUT];

  for (genvar k = 0; k < FANOUT; k++) begin : g_lane
    assign lane[k] = ptr_bus[k*STATE_W +: STATE_W];
  end

  assign nxt = lane[sel];
endmodule

// File: rtl/slice_tile_state.sv
module slice_tile_state
  import slice_tile_pkg::*;
#(
  parameter int STATE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  state_src_e         src,
  input  logic [STATE_W-1:0] nxt,
  output logic [STATE_W-1:0] cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else begin
      case (src)
        SRC_STEP: cur <= nxt;
        SRC_ROOT: cur <= '0;
        default:  cur <= cur;
      endcase
    end
  end
endmodule

// File: rtl/slice_tile.sv
module slice_tile
  import slice_tile_pkg::*;
#(
  parameter int STATE_W = 8,
  parameter int SLICE_W = 2,
  parameter int RULES   = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            pkt_start,
  input  logic                            in_valid,
  input  logic [SLICE_W-1:0]              in_slice,
  input  logic                            tw_en,
  input  logic [STATE_W-1:0]              tw_addr,
  input  logic [(STATE_W << SLICE_W)-1:0] tw_ptrs,
  input  logic [RULES-1:0]                tw_hits,
  output logic                            hit_valid,
  output logic [RULES-1:0]                hit_vec
);
  localparam int PTR_W   = STATE_W << SLICE_W;
  localparam int ENTRY_W = PTR_W + RULES;

  // Named internal events, exposed for the checker
  logic               tbl_we;
  logic [STATE_W-1:0] cur_state;
  logic [STATE_W-1:0] rd_state;
  logic [STATE_W-1:0] next_ptr;
  logic [ENTRY_W-1:0] row;
  state_src_e         src;

  assign tbl_we   = tw_en && !in_valid;
  assign rd_state = pkt_start ? '0 : cur_state;
  assign src      = pick_src(in_valid, pkt_start);

  slice_tile_table #(.ADDR_W(STATE_W), .ENTRY_W(ENTRY_W)) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .waddr (tw_addr),
    .wdata ({tw_ptrs, tw_hits}),
    .raddr (rd_state),
    .rdata (row)
  );

  slice_tile_ptr_mux #(.STATE_W(STATE_W), .SLICE_W(SLICE_W)) u_mux (
    .ptr_bus (row[ENTRY_W-1:RULES]),
    .sel     (in_slice),
    .nxt     (next_ptr)
  );

  slice_tile_state #(.STATE_W(STATE_W)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (src),
    .nxt   (next_ptr),
    .cur   (cur_state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_valid <= 1'b0;
      hit_vec   <= '0;
    end else begin
      hit_valid <= in_valid;
      hit_vec   <= in_valid ? row[RULES-1:0] : '0;
    end
  end
endmodule

// File: rtl/slice_tile_chk.sv
module slice_tile_chk #(
  parameter int STATE_W = 8,
  parameter int RULES   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pkt_start,
  input logic               in_valid,
  input logic               hit_valid,
  input logic [RULES-1:0]   hit_vec,
  input logic [STATE_W-1:0] cur_state,
  input logic [STATE_W-1:0] next_ptr
);
  a_r6_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!hit_valid && hit_vec == '0));

  a_r3_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> hit_valid);

  a_r6_state_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !pkt_start) |=> cur_state == $past(cur_state));

  a_r5_start_roots: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_start && !in_valid) |=> cur_state == '0);

  a_r4_step_taken: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> cur_state == $past(next_ptr));
endmodule

bind slice_tile slice_tile_chk #(.STATE_W(STATE_W), .RULES(RULES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pkt_start (pkt_start),
  .in_valid  (in_valid),
  .hit_valid (hit_valid),
  .hit_vec   (hit_vec),
  .cur_state (cur_state),
  .next_ptr  (next_ptr)
);

// File: tb/test_slice_tile.sv
module test_slice_tile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        pkt_start = 0;
  logic        in_valid = 0;
  logic [1:0]  in_slice = 0;
  logic        tw_en = 0;
  logic [7:0]  tw_addr = 0;
  logic [31:0] tw_ptrs = 0;
  logic [15:0] tw_hits = 0;
  logic        hit_valid;
  logic [15:0] hit_vec;

  int n_checks = 0;
  int n_fails  = 0;
  bit mon_on   = 0;
  bit done     = 0;

  // Bench-side model of the table and the walk
  logic [7:0]  m_ptr [256][4];
  logic [15:0] m_hit [256];
  logic [7:0]  m_state;

  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  slice_tile i_slice_tile (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .in_valid(in_valid),
    .in_slice(in_slice), .tw_en(tw_en), .tw_addr(tw_addr), .tw_ptrs(tw_ptrs),
    .tw_hits(tw_hits), .hit_valid(hit_valid), .hit_vec(hit_vec)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: compare each result against the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (hit_valid) begin
        if (exp_q.size() == 0) check(0, "R3 unexpected result", {16'h0, hit_vec}, 32'h0);
        else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(hit_vec == e, t, {16'h0, hit_vec}, {16'h0, e});
        end
      end else begin
        check(hit_vec == 16'h0, "R6 idle output", {16'h0, hit_vec}, 32'h0);
      end
    end
  end

  // Driver: one slice per call, expected value pushed to the scoreboard
  task automatic send(input logic [1:0] s, input bit start, input string tag,
                      input bit wr = 0, input logic [7:0] wa = 0,
                      input logic [31:0] wp = 0, input logic [15:0] wh = 0);
    logic [7:0] rs;
    rs = start ? 8'd0 : m_state;
    exp_q.push_back(m_hit[rs]);
    tag_q.push_back(tag);
    m_state = m_ptr[rs][s];
    pkt_start = start; in_valid = 1; in_slice = s;
    tw_en = wr; tw_addr = wa; tw_ptrs = wp; tw_hits = wh;   // R7: write must be dropped
    @(negedge clk);
    pkt_start = 0; in_valid = 0; tw_en = 0;
  endtask

  task automatic idle(input bit start);
    if (start) m_state = 8'd0;
    pkt_start = start;
    @(negedge clk);
    pkt_start = 0;
  endtask

  task automatic load(input logic [7:0] a, input logic [31:0] p, input logic [15:0] h);
    tw_en = 1; tw_addr = a; tw_ptrs = p; tw_hits = h;
    @(negedge clk);
    tw_en = 0;
    for (int k = 0; k < 4; k++) m_ptr[a][k] = p[k*8 +: 8];
    m_hit[a] = h;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int a = 0; a < 256; a++) begin
      m_hit[a] = '0;
      for (int k = 0; k < 4; k++) m_ptr[a][k] = '0;
    end
    m_state = 0;

    // R1: reset state
    #(CLK_PERIOD*2 + 1);
    check(!hit_valid && hit_vec == 0, "R1 during reset", {15'h0, hit_valid, hit_vec}, 32'h0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check(!hit_valid && hit_vec == 0, "R1 after reset", {15'h0, hit_valid, hit_vec}, 32'h0);
    mon_on = 1;

    // R2: empty table gives zero vectors
    for (int i = 0; i < 6; i++) send(2'(i), i == 0, "R2 empty table");
    idle(0);

    // R8: program rows 0..7 with distinct vectors and pointers
    for (int s = 0; s < 8; s++) begin
      logic [31:0] p;
      for (int k = 0; k < 4; k++) p[k*8 +: 8] = 8'((s*3 + k*5 + 1) % 8);
      load(8'(s), p, 16'h1 << s | 16'h8000 >> s | 16'(s*16'h0111));
    end

    // R3/R4: walk with varied slice patterns
    for (int i = 0; i < 12; i++) send(2'(i), i == 0, "R3 R4 walk");
    for (int i = 0; i < 8; i++) send(2'(3 - (i % 4)), 0, "R4 descending slices");
    // R6: gaps keep the state
    send(2'd1, 0, "R6 before gap"); idle(0); idle(0);
    send(2'd2, 0, "R6 after gap"); idle(0);
    send(2'd3, 0, "R6 resume");
    // R5: start strobe with and without a slice
    send(2'd0, 0, "R5 pre"); send(2'd1, 1, "R5 start with slice");
    send(2'd2, 0, "R5 follow");
    idle(1);
    send(2'd3, 0, "R5 after lone start");
    send(2'd0, 0, "R5 follow2");
    idle(0);

    // R4 boundary: pointer to state 255
    load(8'd0, {8'd255, 8'd255, 8'd255, 8'd255}, 16'h0F0F);
    load(8'd255, {8'd1, 8'd2, 8'd3, 8'd0}, 16'hFFFF);
    send(2'd2, 1, "R8 new row 0");
    send(2'd0, 0, "R4 state 255");
    send(2'd1, 0, "R4 from 255");

    // R7: write during a valid slice is dropped
    send(2'd3, 1, "R7 carrier", 1, 8'd0, 32'h0, 16'hDEAD);
    send(2'd0, 1, "R7 row 0 unchanged");
    send(2'd1, 0, "R7 follow");
    idle(0);
    // R8: write between packets takes effect
    load(8'd0, {8'd4, 8'd5, 8'd6, 8'd7}, 16'hBEEF);
    send(2'd1, 1, "R8 rewritten row");
    send(2'd0, 0, "R8 follow");
    idle(0); idle(0);

    check(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule